// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block is the serial-side front end of a small memory slave on an SPI bus. It oversamples chip select, serial clock, serial input and an active-low pause input with the system clock. A transfer opens with an 8-bit opcode and, for memory commands, a 24-bit address sent most significant bit first. Write payload bytes are stored into an internal register-file backing store. Read bytes are returned either one bit per falling serial-clock edge on the output pin, or two bits per falling edge, with the input line turned around to carry the second bit.

A pause input freezes the transfer mid-stream without deselecting the slave. The busy flag of a self-timed operation running elsewhere in the memory arrives as an input. It is reported through a status opcode, and it keeps the slave out of standby after deselection until the operation ends. The address counter spans a 32 KB space (15 bits) and wraps from its top back to zero. The backing store is smaller than that space and is indexed by the low address bits.

Top module: `spiFlashFront`

## Requirements
- R1: Both clock polarities are accepted: the serial clock may idle low (mode 0) or high (mode 3) while chip select is high, and transfers behave identically in both.
- R2: Opcode, address and write bits are captured on rising serial-clock edges; output pins change only after falling serial-clock edges and hold their value through the high phase.
- R3: A transfer starts only on a falling edge of chip select; a rising edge of chip select aborts any transfer, drops partly shifted bits (a partial write byte is never stored) and clears the bit counter.
- R4: While chip select is high, clock and input activity have no effect on state or storage and both output enables stay low.
- R5: Opcode 0x03 reads: after the last address bit, each falling edge drives the next data bit (MSB first) on soOut with soOe high; ioOe stays low.
- R6: Opcode 0x3B is a dual read: after the address, 8 dummy clocks pass, then each falling edge drives two bits, the higher-order bit on soOut and the lower-order bit on ioOut, with both enables high.
- R7: Opcode 0x02 programs: each complete 8-bit payload byte after the address is written at the current address.
- R8: The address increments after every byte read or written and wraps from 0x7FFF to 0x0000; storage is indexed by the low 8 address bits, so 0x0100 aliases 0x0000.
- R9: The pause input (holdN low) takes effect only while chip select is low and the serial clock is low; once paused, both enables are low and clock and input edges are ignored, and releasing holdN resumes the transfer at the same bit with the same output value.
- R10: Opcode 0x05 returns a status byte, repeated for as long as clocks continue, with bit 0 equal to busyIn and bits 7..1 zero.
- R11: standby is high only while chip select is high and busyIn is low; a pause does not alter busyIn handling.
- R12: Any other opcode produces no output and writes nothing until chip select rises.
- R13: After reset both output enables are low and the backing store reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data input |
| holdN | input | 1 | Active-low pause request |
| busyIn | input | 1 | Busy flag of a self-timed operation |
| soOut | output | 1 | Serial data output (high bit in dual mode) |
| soOe | output | 1 | Output enable for soOut |
| ioOut | output | 1 | Second data bit driven on the input line in dual mode |
| ioOe | output | 1 | Output enable for the turned-around input line |
| standby | output | 1 | Slave is deselected and idle |

## Verification
The bench builds the block with its default parameters: a 15-bit address counter, a 256-byte store and 8 dummy clocks. These values make both the address wrap at 0x7FFF and the aliasing of 0x0100 onto 0x0000 reachable within a few bytes. With the serial clock running at one sixteenth of the system clock, every oversampling latency falls inside a half period. The bench can therefore probe mid-byte pauses, aborted partial bytes and turned-around dual lanes at bit granularity.

// File: rtl/spiFrontPkg.sv
package spiFrontPkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_FETCH, S_DATA, S_WRITE, S_SKIP
  } stateT;

  typedef enum logic [1:0] {K_READ, K_WRITE, K_STAT} kindT;

  // strobes from control to datapath, one system cycle each
  typedef struct packed {
    logic shiftIn;   // capture sampled input bit
    logic addrLoad;  // take shifted bits as address
    logic fetch;     // load output byte from store, advance address
    logic statLoad;  // load output byte with status
    logic wrCommit;  // store shifted byte, advance address
    logic drive1;    // put one bit on the output pin
    logic drive2;    // put two bits on the output lanes
  } strobeT;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_DUAL = 8'h3B;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_STAT = 8'h05;

endpackage

// File: rtl/spiFrontCtrl.sv
module spiFrontCtrl
  import spiFrontPkg::*;
#(
  parameter int DUMMY_CLKS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sck,
  input  logic         si,
  input  logic         holdN,
  input  logic [7:0]   nextByte,
  output logic         siSync,
  output logic         csSync,
  output strobeT       strb,
  output logic         soOe,
  output logic         ioOe
);

  localparam int CNT_W = 5;
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CLKS - 1);

  logic csS, csP, sckS, sckP, siS, holdNS;
  logic holdActive, holdActiveN;
  logic sckRise, sckFall;
  stateT state, stateN;
  kindT kind, kindN;
  logic isDual, dualN;
  logic driving, drivingN;
  logic [CNT_W-1:0] bitCnt, cntN;

  // input sampling and edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csS <= 1'b1; csP <= 1'b1;
      sckS <= 1'b0; sckP <= 1'b0;
      siS <= 1'b0; holdNS <= 1'b1;
    end else begin
      csS <= csN; csP <= csS;
      sckS <= sck; sckP <= sckS;
      siS <= si; holdNS <= holdN;
    end
  end

  assign sckRise = sckS & ~sckP & ~holdActive;
  assign sckFall = ~sckS & sckP & ~holdActive;

  // pause may only begin with select low and clock low
  always_comb begin
    if (csS)             holdActiveN = 1'b0;
    else if (holdActive) holdActiveN = ~holdNS;
    else                 holdActiveN = ~holdNS & ~sckS;
  end

  always_comb begin
    strb = '0;
    stateN = state;
    cntN = bitCnt;
    kindN = kind;
    dualN = isDual;
    drivingN = driving;
    if (csS) begin
      stateN = S_IDLE;
      cntN = '0;
      drivingN = 1'b0;
    end else if (csP) begin
      stateN = S_CMD;
      cntN = '0;
      drivingN = 1'b0;
    end else begin
      case (state)
        S_CMD: if (sckRise) begin
          strb.shiftIn = 1'b1;
          cntN = bitCnt + 5'd1;
          if (bitCnt == 5'd7) begin
            cntN = '0;
            case (nextByte)
              OP_READ: begin stateN = S_ADDR;  kindN = K_READ;  dualN = 1'b0; end
              OP_DUAL: begin stateN = S_ADDR;  kindN = K_READ;  dualN = 1'b1; end
              OP_PROG: begin stateN = S_ADDR;  kindN = K_WRITE; dualN = 1'b0; end
              OP_STAT: begin stateN = S_FETCH; kindN = K_STAT;  dualN = 1'b0; end
              default: stateN = S_SKIP;
            endcase
          end
        end
        S_ADDR: if (sckRise) begin
          strb.shiftIn = 1'b1;
          cntN = bitCnt + 5'd1;
          if (bitCnt == 5'd23) begin
            cntN = '0;
            strb.addrLoad = 1'b1;
            if (kind == K_WRITE) stateN = S_WRITE;
            else if (isDual)     stateN = S_DUMMY;
            else                 stateN = S_FETCH;
          end
        end
        S_DUMMY: if (sckRise) begin
          cntN = bitCnt + 5'd1;
          if (bitCnt == DUMMY_LAST) begin
            cntN = '0;
            stateN = S_FETCH;
          end
        end
        S_FETCH: begin
          if (kind == K_STAT) strb.statLoad = 1'b1;
          else                strb.fetch = 1'b1;
          cntN = '0;
          stateN = S_DATA;
        end
        S_DATA: if (sckFall) begin
          drivingN = 1'b1;
          if (isDual) strb.drive2 = 1'b1;
          else        strb.drive1 = 1'b1;
          cntN = bitCnt + 5'd1;
          if (bitCnt == (isDual ? 5'd3 : 5'd7)) begin
            cntN = '0;
            if (kind == K_STAT) strb.statLoad = 1'b1;
            else                strb.fetch = 1'b1;
          end
        end
        S_WRITE: if (sckRise) begin
          strb.shiftIn = 1'b1;
          cntN = bitCnt + 5'd1;
          if (bitCnt == 5'd7) begin
            cntN = '0;
            strb.wrCommit = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kind <= K_READ;
      isDual <= 1'b0;
      driving <= 1'b0;
      bitCnt <= '0;
      holdActive <= 1'b0;
    end else begin
      state <= stateN;
      kind <= kindN;
      isDual <= dualN;
      driving <= drivingN;
      bitCnt <= cntN;
      holdActive <= holdActiveN;
    end
  end

  assign soOe = driving & ~holdActive & ~csS;
  assign ioOe = soOe & isDual;
  assign siSync = siS;
  assign csSync = csS;

  a_r9_hold_freezes: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |-> !(strb.shiftIn || strb.wrCommit || strb.drive1 || strb.drive2));
  a_r9_hold_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdActive) |-> !$past(sckS));
  a_r3_abort_on_deselect: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> state == S_IDLE);
  a_r3_start_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && $past(state) == S_IDLE) |-> ($past(csP) && !$past(csS)));
  a_r6_io_needs_so: assert property (@(posedge clk) disable iff (!rstN)
    ioOe |-> soOe);

endmodule

// File: rtl/spiFrontData.sv
module spiFrontData
  import spiFrontPkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int MEM_DEPTH = 256
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         siSync,
  input  logic         busyIn,
  input  strobeT       strb,
  output logic [7:0]   nextByte,
  output logic         soOut,
  output logic         ioOut
);

  localparam int IDX_W = $clog2(MEM_DEPTH);

  logic [ADDR_W-2:0] inShift;
  logic [ADDR_W-1:0] nextIn;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        outShift;
  logic              soReg, ioReg;
  logic [7:0]        mem [MEM_DEPTH];

  assign nextIn = {inShift, siSync};
  assign nextByte = nextIn[7:0];

  // store smaller than the address space: alias on low bits
  generate
    if (IDX_W < ADDR_W) begin : g_alias
      assign idx = addr[IDX_W-1:0];
    end else begin : g_full
      assign idx = IDX_W'(addr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift <= '0;
      addr <= '0;
      outShift <= '0;
      soReg <= 1'b0;
      ioReg <= 1'b0;
    end else begin
      if (strb.shiftIn) inShift <= nextIn[ADDR_W-2:0];
      if (strb.addrLoad) addr <= nextIn;
      else if (strb.fetch || strb.wrCommit) addr <= addr + 1'b1;
      if (strb.fetch)         outShift <= mem[idx];
      else if (strb.statLoad) outShift <= {7'b0, busyIn};
      else if (strb.drive2)   outShift <= {outShift[5:0], 2'b00};
      else if (strb.drive1)   outShift <= {outShift[6:0], 1'b0};
      if (strb.drive1 || strb.drive2) soReg <= outShift[7];
      if (strb.drive2) ioReg <= outShift[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (strb.wrCommit) begin
      mem[idx] <= nextByte;
    end
  end

  assign soOut = soReg;
  assign ioOut = ioReg;

  a_r2_out_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.drive1 || strb.drive2) |-> $stable(soReg));
  a_r8_addr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.fetch || strb.wrCommit) && !strb.addrLoad && addr == '1) |=> addr == '0);

endmodule

// File: rtl/spiFlashFront.sv
module spiFlashFront
  import spiFrontPkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int MEM_DEPTH  = 256,
  parameter int DUMMY_CLKS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  input  logic holdN,
  input  logic busyIn,
  output logic soOut,
  output logic soOe,
  output logic ioOut,
  output logic ioOe,
  output logic standby
);

  strobeT     strb;
  logic       siSync, csSync;
  logic [7:0] nextByte;

  spiFrontCtrl #(.DUMMY_CLKS(DUMMY_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .nextByte(nextByte), .siSync(siSync), .csSync(csSync), .strb(strb),
    .soOe(soOe), .ioOe(ioOe)
  );

  spiFrontData #(.ADDR_W(ADDR_W), .MEM_DEPTH(MEM_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .siSync(siSync), .busyIn(busyIn), .strb(strb),
    .nextByte(nextByte), .soOut(soOut), .ioOut(ioOut)
  );

  assign standby = csSync & ~busyIn;

  a_r11_selected_not_standby: assert property (@(posedge clk) disable iff (!rstN)
    (soOe || ioOe) |-> !standby);

endmodule

// File: tb/tb_spiFlashFront.sv
module tb_spiFlashFront;

  localparam int HALF = 8;
  localparam int WD_CYCLES = 150000;

  typedef struct packed {
    logic        m3;
    logic        dual;
    logic [23:0] addr;
    logic [7:0]  data;
  } vecT;

  localparam vecT VEC [6] = '{
    '{1'b0, 1'b0, 24'h000010, 8'hA5},
    '{1'b1, 1'b0, 24'h000123, 8'h3C},
    '{1'b0, 1'b1, 24'h0040FE, 8'h96},
    '{1'b1, 1'b1, 24'h007FF0, 8'h5A},
    '{1'b0, 1'b0, 24'hFF0042, 8'hC3},
    '{1'b1, 1'b1, 24'h000001, 8'h81}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0, holdN = 1'b1, busyIn = 1'b0;
  logic soOut, soOe, ioOut, ioOe, standby;

  int nChk = 0, nFail = 0, oeBad = 0, stableBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spiFlashFront dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .busyIn(busyIn), .soOut(soOut), .soOe(soOe), .ioOut(ioOut), .ioOe(ioOe),
    .standby(standby)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel(input bit m3);
    sck = m3; tick(2); csN = 1'b0; tick(4);
  endtask

  task automatic desel(input bit m3);
    tick(2); sck = m3; tick(4); csN = 1'b1; tick(6);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = b[i]; tick(HALF);
      sck = 1'b1; tick(HALF);
    end
  endtask

  task automatic sendAddr(input logic [23:0] a);
    sendByte(a[23:16]); sendByte(a[15:8]); sendByte(a[7:0]);
  endtask

  task automatic recvByte(input bit dual, output logic [7:0] b);
    b = '0;
    if (dual) begin
      for (int i = 0; i < 4; i++) begin
        sck = 1'b0; tick(HALF);
        b = {b[5:0], soOut, ioOut};
        if (!soOe || !ioOe) oeBad++;
        sck = 1'b1; tick(HALF);
        if (soOut != b[1] || ioOut != b[0]) stableBad++;
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        sck = 1'b0; tick(HALF);
        b = {b[6:0], soOut};
        if (!soOe || ioOe) oeBad++;
        sck = 1'b1; tick(HALF);
        if (soOut != b[0]) stableBad++;
      end
    end
  endtask

  task automatic step(output logic b);
    sck = 1'b0; tick(HALF);
    b = soOut;
    sck = 1'b1; tick(HALF);
  endtask

  task automatic progByte(input bit m3, input logic [23:0] a, input logic [7:0] d);
    sel(m3); sendByte(8'h02); sendAddr(a); sendByte(d); desel(m3);
  endtask

  task automatic readOne(input bit m3, input bit dual, input logic [23:0] a, output logic [7:0] d);
    sel(m3);
    sendByte(dual ? 8'h3B : 8'h03);
    sendAddr(a);
    if (dual) sendByte(8'h00);
    recvByte(dual, d);
    desel(m3);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, got2, got3;
    logic bitA, bitB;
    bit bad;
    tick(4);
    rstN = 1'b1;
    tick(4);

    // R13: reset state
    chk(!soOe && !ioOe, "R13 enables after reset", {soOe, ioOe}, 0);
    chk(standby, "R11 standby after reset", standby, 1);
    readOne(1'b0, 1'b0, 24'h000055, got);
    chk(got == 8'h00, "R13 store cleared", got, 8'h00);

    // table: program then read back in each mode
    for (int v = 0; v < 6; v++) begin
      progByte(VEC[v].m3, VEC[v].addr, VEC[v].data);
      readOne(VEC[v].m3, VEC[v].dual, VEC[v].addr, got);
      if (VEC[v].dual) chk(got == VEC[v].data, VEC[v].m3 ? "R6 dual read mode 3 (R1)" : "R6 dual read mode 0", got, VEC[v].data);
      else             chk(got == VEC[v].data, VEC[v].m3 ? "R5 read mode 3 (R1)" : "R5 read mode 0 (R7)", got, VEC[v].data);
    end

    // R4: activity with select high has no effect
    bad = 1'b0;
    for (int i = 0; i < 16; i++) begin
      sck = ~sck; si = ~si; tick(HALF);
      if (soOe || ioOe) bad = 1'b1;
    end
    sck = 1'b0; tick(4);
    chk(!bad, "R4 enables low while deselected", bad, 0);
    readOne(1'b0, 1'b0, 24'h000010, got);
    chk(got == 8'hA5, "R4 store untouched while deselected", got, 8'hA5);

    // R3: abort a partial opcode, then a partial write byte
    sel(1'b0);
    for (int i = 0; i < 5; i++) begin sck = 1'b0; si = i[0]; tick(HALF); sck = 1'b1; tick(HALF); end
    desel(1'b0);
    readOne(1'b0, 1'b0, 24'h000010, got);
    chk(got == 8'hA5, "R3 counter cleared after abort", got, 8'hA5);
    sel(1'b0); sendByte(8'h02); sendAddr(24'h000123);
    for (int i = 0; i < 4; i++) begin sck = 1'b0; si = 1'b1; tick(HALF); sck = 1'b1; tick(HALF); end
    desel(1'b0);
    readOne(1'b1, 1'b0, 24'h000123, got);
    chk(got == 8'h3C, "R3 partial write dropped", got, 8'h3C);

    // R12: unknown opcode
    sel(1'b0); sendByte(8'h9F); sendAddr(24'h000010);
    bad = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; si = 1'b0; tick(HALF);
      if (soOe || ioOe) bad = 1'b1;
      sck = 1'b1; tick(HALF);
    end
    desel(1'b0);
    chk(!bad, "R12 no output on unknown opcode", bad, 0);
    readOne(1'b0, 1'b0, 24'h000010, got);
    chk(got == 8'hA5, "R12 nothing written on unknown opcode", got, 8'hA5);

    // R7 / R8: burst write across the wrap, then burst reads
    sel(1'b0); sendByte(8'h02); sendAddr(24'h007FFE);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33);
    desel(1'b0);
    sel(1'b0); sendByte(8'h03); sendAddr(24'h007FFE);
    recvByte(1'b0, got); recvByte(1'b0, got2); recvByte(1'b0, got3);
    desel(1'b0);
    chk(got == 8'h11, "R7 burst byte 0", got, 8'h11);
    chk(got2 == 8'h22, "R7 burst byte 1", got2, 8'h22);
    chk(got3 == 8'h33, "R8 wrap to 0x0000", got3, 8'h33);
    readOne(1'b0, 1'b0, 24'h000100, got);
    chk(got == 8'h33, "R8 0x0100 aliases 0x0000", got, 8'h33);
    sel(1'b1); sendByte(8'h3B); sendAddr(24'h007FFF); sendByte(8'h00);
    recvByte(1'b1, got); recvByte(1'b1, got2);
    desel(1'b1);
    chk(got == 8'h22 && got2 == 8'h33, "R6 dual burst across wrap (R8)", {got, got2}, 16'h2233);

    // R9: pause mid-byte with clock low
    sel(1'b0); sendByte(8'h03); sendAddr(24'h000010);
    got = '0;
    for (int i = 0; i < 3; i++) begin step(bitA); got = {got[6:0], bitA}; end
    sck = 1'b0; tick(HALF);
    bitA = soOut;
    holdN = 1'b0; busyIn = 1'b1; tick(4);
    chk(!soOe && !ioOe, "R9 enables low while paused", {soOe, ioOe}, 0);
    for (int i = 0; i < 4; i++) begin sck = 1'b1; si = 1'b1; tick(HALF); sck = 1'b0; si = 1'b0; tick(HALF); end
    holdN = 1'b1; tick(4);
    chk(soOe && soOut == bitA, "R9 resume same bit", {soOe, soOut}, {1'b1, bitA});
    chk(!standby, "R11 no standby while selected and busy", standby, 0);
    sck = 1'b1; tick(HALF);
    got = {got[6:0], bitA};
    for (int i = 0; i < 4; i++) begin step(bitA); got = {got[6:0], bitA}; end
    recvByte(1'b0, got2);
    desel(1'b0);
    chk(got == 8'hA5, "R9 byte intact after pause", got, 8'hA5);
    chk(got2 == 8'h00, "R9 address advanced once", got2, 8'h00);
    chk(!standby, "R11 busy blocks standby after deselect", standby, 0);
    busyIn = 1'b0; tick(4);
    chk(standby, "R11 standby once busy clears", standby, 1);

    // R9: pause requested with clock high waits for clock low
    sel(1'b0); sendByte(8'h03); sendAddr(24'h000010);
    step(bitA);
    holdN = 1'b0; tick(4);
    chk(soOe, "R9 pause not taken with clock high", soOe, 1);
    sck = 1'b0; tick(HALF);
    chk(!soOe, "R9 pause taken once clock low", soOe, 0);
    sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
    holdN = 1'b1; tick(4);
    bitB = soOut;
    sck = 1'b1; tick(HALF);
    desel(1'b0);
    chk({bitA, bitB} == 2'b10, "R9 bits 7 and 6 across pause", {bitA, bitB}, 2'b10);

    // R10: status byte
    busyIn = 1'b1;
    sel(1'b1); sendByte(8'h05); recvByte(1'b0, got); recvByte(1'b0, got2); desel(1'b1);
    chk(got == 8'h01 && got2 == 8'h01, "R10 status busy repeated", {got, got2}, 16'h0101);
    busyIn = 1'b0;
    sel(1'b0); sendByte(8'h05); recvByte(1'b0, got); desel(1'b0);
    chk(got == 8'h00, "R10 status idle", got, 8'h00);

    // R2: output stable through every high phase, enables correct in data phases
    chk(stableBad == 0, "R2 output held during high phase", stableBad, 0);
    chk(oeBad == 0, "R5 R6 enables during data phase", oeBad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule